// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the integer execution unit of a pipeline's execute stage. It takes a 32-bit first operand, a 32-bit second operand, a 16-bit immediate and an operation code. It returns a 32-bit result and a flag that asks for an arithmetic overflow trap. The unit computes add and subtract, the bitwise operations, three kinds of shift, loading an immediate into the upper half of a word, and six signed set-on-condition compares that write 1 or 0. It also prepares the immediate operand, choosing sign or zero extension from the operation.

The datapath is purely combinational. It sits between a producer and a consumer with a valid/ready pass-through. A result is offered on the same cycle its operands arrive. Back-pressure from the consumer is handed straight back to the producer. While `in_valid` is high and `out_ready` is low, the producer must hold every operand input steady, so the offered result stays unchanged until the consumer takes it. A transfer happens on a clock edge where `out_valid` and `out_ready` are both high.

Top module: `int_alu_trap`

## Requirements
- R1: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` on every cycle. While the offer is stalled with steady inputs, `result` and `ovf_trap` stay stable. While `in_valid` is low, `out_valid` is low.
- R2: Code 0 (add) gives `A + B` and code 1 (subtract) gives `A - B`, both modulo 2^32. With `is_unsigned`=0, `ovf_trap` is 1 exactly when the true signed result falls outside the signed 32-bit range.
- R3: With `is_unsigned`=1, add and subtract never raise `ovf_trap`. No operation other than signed add or subtract ever raises it.
- R4: Codes 2, 3 and 4 give the bitwise AND, OR and XOR of A and B. When `use_imm`=1 for these codes, B is the immediate zero-extended to 32 bits.
- R5: Codes 5, 6 and 7 shift A as follows: 5 is logical left, 6 is logical right, 7 is arithmetic right. The shift amount is bits 4:0 of B, and higher bits of B are ignored.
- R6: `use_imm`=1 replaces B with the immediate. For add, subtract, the shifts and the compares, the immediate is sign-extended from bit 15. With `use_imm`=0, B is `op_b`.
- R7: Code 8 gives the immediate in bits 31:16 and zero in bits 15:0. A, `op_b` and `use_imm` have no effect.
- R8: Codes 9 to 14 compare A with B as signed numbers, in the order less-than, greater-than, less-or-equal, greater-or-equal, equal, not-equal. The result is 1 when the condition holds and 0 otherwise, and `is_unsigned` has no effect.
- R9: Code 15 is unused. It gives result 0 and no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Producer offers an operation |
| in_ready | output | 1 | Unit can accept the offered operation |
| op_code | input | 4 | Operation code (see R2 to R9) |
| is_unsigned | input | 1 | 1 selects the non-trapping add/subtract form |
| use_imm | input | 1 | 1 takes the second operand from the immediate |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, register form |
| imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result is offered to the consumer |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow trap request |

## Verification
Add and subtract are driven at the signed limits (largest positive plus one, most negative minus one, minus one plus one). These cases separate true signed overflow from a plain carry-out, and the same vectors sent with the unsigned qualifier show that the trap is gated. Immediates are sent with bit 15 set to both the logical and the arithmetic forms, which tells zero extension from sign extension. Shift amounts of 0, 31 and values above 31 show that only the low five bits count, and a negative operand shows arithmetic fill against logical fill. The compares are tried with equal operands and with operands of opposite sign, which tells signed from unsigned ordering. Randomised operands over every code then check each result against a behavioural model.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_SHA = 4'd7,
    OP_UPI = 4'd8,
    OP_CLT = 4'd9,
    OP_CGT = 4'd10,
    OP_CLE = 4'd11,
    OP_CGE = 4'd12,
    OP_CEQ = 4'd13,
    OP_CNE = 4'd14,
    OP_NUL = 4'd15
  } alu_op_e;

  function automatic logic is_logic_op(alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic is_cmp_op(alu_op_e op);
    return (op >= OP_CLT) && (op <= OP_CNE);
  endfunction
endpackage

// File: rtl/int_alu_opnd.sv
module int_alu_opnd
  import int_alu_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 16
) (
  input  alu_op_e       op,
  input  logic          use_imm,
  input  logic [W-1:0]  reg_b,
  input  logic [IW-1:0] imm,
  output logic [W-1:0]  b_eff
);
  localparam int unsigned PAD = W - IW;

  logic [W-1:0] imm_zx;
  logic [W-1:0] imm_sx;

  always_comb begin
    imm_zx = {{PAD{1'b0}}, imm};
    imm_sx = {{PAD{imm[IW-1]}}, imm};
    if (!use_imm)
      b_eff = reg_b;
    else if (is_logic_op(op))
      b_eff = imm_zx;
    else
      b_eff = imm_sx;
  end
endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         sgn_ovf
);
  logic [W-1:0] b_x;

  always_comb begin
    b_x     = sub ? ~b : b;
    sum     = a + b_x + {{(W-1){1'b0}}, sub};
    sgn_ovf = (a[W-1] == b_x[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int unsigned W = 32
) (
  input  logic                 go_left,
  input  logic                 arith,
  input  logic [W-1:0]         a,
  input  logic [$clog2(W)-1:0] amt,
  output logic [W-1:0]         y
);
  localparam int unsigned SW = $clog2(W);

  logic [W-1:0] stg [0:SW];
  logic         fill;

  assign fill   = arith && !go_left && a[W-1];
  assign stg[0] = a;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int unsigned DIST = 1 << s;
    logic [W-1:0] shl;
    logic [W-1:0] shr;
    always_comb begin
      shl = stg[s] << DIST;
      shr = (stg[s] >> DIST) | (fill ? ~({W{1'b1}} >> DIST) : {W{1'b0}});
    end
    assign stg[s+1] = amt[s] ? (go_left ? shl : shr) : stg[s];
  end

  assign y = stg[SW];
endmodule

// File: rtl/int_alu_cmp.sv
module int_alu_cmp
  import int_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit
);
  logic lt;
  logic eq;

  always_comb begin
    lt = $signed(a) < $signed(b);
    eq = (a == b);
    unique case (op)
      OP_CLT:  hit = lt;
      OP_CGT:  hit = !lt && !eq;
      OP_CLE:  hit = lt || eq;
      OP_CGE:  hit = !lt;
      OP_CEQ:  hit = eq;
      OP_CNE:  hit = !eq;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_alu_trap.sv
module int_alu_trap
  import int_alu_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned IW = IMM_W
) (
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    op_code,
  input  logic          is_unsigned,
  input  logic          use_imm,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [IW-1:0] imm,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  result,
  output logic          ovf_trap
);
  localparam int unsigned SW  = $clog2(W);
  localparam int unsigned LOW = W - IW;

  alu_op_e      op;
  logic [W-1:0] b_eff;
  logic [W-1:0] as_sum;
  logic         as_ovf;
  logic [W-1:0] sh_y;
  logic         cmp_hit;

  assign op        = alu_op_e'(op_code);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  int_alu_opnd #(.W(W), .IW(IW)) u_opnd (
    .op(op), .use_imm(use_imm), .reg_b(op_b), .imm(imm), .b_eff(b_eff)
  );

  int_alu_addsub #(.W(W)) u_addsub (
    .sub(op == OP_SUB), .a(op_a), .b(b_eff), .sum(as_sum), .sgn_ovf(as_ovf)
  );

  int_alu_shift #(.W(W)) u_shift (
    .go_left(op == OP_SHL), .arith(op == OP_SHA), .a(op_a),
    .amt(b_eff[SW-1:0]), .y(sh_y)
  );

  int_alu_cmp #(.W(W)) u_cmp (
    .op(op), .a(op_a), .b(b_eff), .hit(cmp_hit)
  );

  always_comb begin
    ovf_trap = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        result   = as_sum;
        ovf_trap = as_ovf && !is_unsigned;
      end
      OP_AND:                 result = op_a & b_eff;
      OP_OR:                  result = op_a | b_eff;
      OP_XOR:                 result = op_a ^ b_eff;
      OP_SHL, OP_SHR, OP_SHA: result = sh_y;
      OP_UPI:                 result = {imm, {LOW{1'b0}}};
      OP_CLT, OP_CGT, OP_CLE, OP_CGE, OP_CEQ, OP_CNE:
                              result = {{(W-1){1'b0}}, cmp_hit};
      default:                result = {W{1'b0}};
    endcase
  end
endmodule

module int_alu_trap_chk
  import int_alu_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned IW = IMM_W
) (
  input logic          in_valid,
  input logic [3:0]    op_code,
  input logic          is_unsigned,
  input logic          use_imm,
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic [IW-1:0] imm,
  input logic [W-1:0]  result,
  input logic          ovf_trap
);
  localparam int unsigned LOW = W - IW;

  logic known;
  assign known = (in_valid === 1'b1) &&
                 !$isunknown({op_code, is_unsigned, use_imm, op_a, op_b, imm, result, ovf_trap});

  always_comb begin
    if (known) begin
      // R3: the unsigned forms and all non-arithmetic codes never trap
      a_r3_no_overflow: assert (!((is_unsigned || op_code > 4'd1) && ovf_trap))
        else $error("a_r3_no_overflow");
      // R2: the trap agrees with the operand and result signs
      if (op_code == 4'd0 && !is_unsigned && !use_imm)
        a_r2_add_trap: assert (ovf_trap == ((op_a[W-1] == op_b[W-1]) && (result[W-1] != op_a[W-1])))
          else $error("a_r2_add_trap");
      if (op_code == 4'd1 && !is_unsigned && !use_imm)
        a_r2_sub_trap: assert (ovf_trap == ((op_a[W-1] != op_b[W-1]) && (result[W-1] != op_a[W-1])))
          else $error("a_r2_sub_trap");
      // R5: a zero register shift amount leaves A unchanged
      if (op_code >= 4'd5 && op_code <= 4'd7 && !use_imm && op_b[4:0] == 5'd0)
        a_r5_shift_zero: assert (result == op_a) else $error("a_r5_shift_zero");
      // R7: the upper-immediate load clears the low half
      if (op_code == 4'd8)
        a_r7_upper_imm: assert (result == {imm, {LOW{1'b0}}}) else $error("a_r7_upper_imm");
      // R8: compares yield 0 or 1 only
      if (op_code >= 4'd9 && op_code <= 4'd14)
        a_r8_set_bool: assert (result[W-1:1] == '0) else $error("a_r8_set_bool");
      // R9: the unused code gives zero
      if (op_code == 4'd15)
        a_r9_unused_zero: assert (result == '0) else $error("a_r9_unused_zero");
    end
  end
endmodule

bind int_alu_trap int_alu_trap_chk #(.W(W), .IW(IW)) chk_i (
  .in_valid(in_valid), .op_code(op_code), .is_unsigned(is_unsigned),
  .use_imm(use_imm), .op_a(op_a), .op_b(op_b), .imm(imm),
  .result(result), .ovf_trap(ovf_trap)
);

// File: tb/int_alu_trap_tb.sv
module int_alu_trap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid, in_ready, is_unsigned, use_imm, out_valid, out_ready, ovf_trap;
  logic [3:0]  op_code;
  logic [31:0] op_a, op_b, result;
  logic [15:0] imm;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  int_alu_trap dut_i (
    .in_valid(in_valid), .in_ready(in_ready), .op_code(op_code),
    .is_unsigned(is_unsigned), .use_imm(use_imm), .op_a(op_a), .op_b(op_b),
    .imm(imm), .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .ovf_trap(ovf_trap)
  );

  function automatic string req_of(int op, bit ui);
    if (ui && op != 8 && !(op inside {2, 3, 4})) return "R6";
    if (op <= 1)  return "R2";
    if (op <= 4)  return "R4";
    if (op <= 7)  return "R5";
    if (op == 8)  return "R7";
    if (op <= 14) return "R8";
    return "R9";
  endfunction

  function automatic logic [32:0] model(int op, logic [31:0] a, logic [31:0] b,
                                        logic [15:0] im, bit ui, bit un);
    logic [31:0] ext, bb, r;
    longint      sa, sb, s;
    bit          t;
    t   = 1'b0;
    ext = (op inside {2, 3, 4}) ? {16'h0, im} : {{16{im[15]}}, im};
    bb  = ui ? ext : b;
    sa  = longint'($signed(a));
    sb  = longint'($signed(bb));
    r   = 32'h0;
    case (op)
      0:  begin s = sa + sb; r = a + bb; t = !un && (s > 64'sd2147483647 || s < -64'sd2147483648); end
      1:  begin s = sa - sb; r = a - bb; t = !un && (s > 64'sd2147483647 || s < -64'sd2147483648); end
      2:  r = a & bb;
      3:  r = a | bb;
      4:  r = a ^ bb;
      5:  r = a << bb[4:0];
      6:  r = a >> bb[4:0];
      7:  r = $signed(a) >>> bb[4:0];
      8:  r = {im, 16'h0};
      9:  r = {31'h0, sa < sb};
      10: r = {31'h0, sa > sb};
      11: r = {31'h0, sa <= sb};
      12: r = {31'h0, sa >= sb};
      13: r = {31'h0, sa == sb};
      14: r = {31'h0, sa != sb};
      default: r = 32'h0;
    endcase
    return {t, r};
  endfunction

  task automatic check(string req, string what, logic [32:0] got, logic [32:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(int op, logic [31:0] a, logic [31:0] b, logic [15:0] im, bit ui, bit un);
    @(posedge clk); #1;
    in_valid = 1'b1; out_ready = 1'b1;
    op_code = op[3:0]; op_a = a; op_b = b; imm = im; use_imm = ui; is_unsigned = un;
    @(negedge clk);
    check("R1", "out_valid", {32'h0, out_valid}, 33'h1);
    check(req_of(op, ui), $sformatf("op %0d", op), {ovf_trap, result}, model(op, a, b, im, ui, un));
  endtask

  initial begin
    in_valid = 0; out_ready = 0; op_code = 0; op_a = 0; op_b = 0;
    imm = 0; use_imm = 0; is_unsigned = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset out_valid", {32'h0, out_valid}, 33'h0);
    rst_n = 1'b1;
    // R2 / R3 signed limits
    apply(0, 32'h7fffffff, 32'h1, 16'h0, 0, 0);
    apply(0, 32'h7fffffff, 32'h1, 16'h0, 0, 1);
    apply(1, 32'h80000000, 32'h1, 16'h0, 0, 0);
    apply(1, 32'h80000000, 32'h1, 16'h0, 0, 1);
    apply(0, 32'hffffffff, 32'h1, 16'h0, 0, 0);
    apply(1, 32'h0, 32'h80000000, 16'h0, 0, 0);
    // R6 sign extension, R4 zero extension
    apply(0, 32'h10, 32'h0, 16'hffff, 1, 0);
    apply(2, 32'hffffffff, 32'h0, 16'hffff, 1, 0);
    apply(4, 32'h12345678, 32'h0, 16'h8001, 1, 0);
    // R5 shifts
    apply(7, 32'h80000000, 32'd31, 16'h0, 0, 0);
    apply(6, 32'h80000000, 32'd31, 16'h0, 0, 0);
    apply(5, 32'h1, 32'd33, 16'h0, 0, 0);
    apply(7, 32'hf0000000, 32'h0, 16'h0, 0, 0);
    // R7 upper immediate with A and use_imm having no effect
    apply(8, 32'hdeadbeef, 32'hffffffff, 16'habcd, 0, 0);
    apply(8, 32'h12345678, 32'h0, 16'h8000, 1, 1);
    // R8 compares, signed, qualifier ignored
    for (int c = 9; c <= 14; c++) begin
      apply(c, 32'h5, 32'h5, 16'h0, 0, 0);
      apply(c, 32'hffffffff, 32'h1, 16'h0, 0, 1);
      apply(c, 32'h3, 32'h0, 16'hfffe, 1, 0);
    end
    // R9 unused code
    apply(15, 32'hffffffff, 32'hffffffff, 16'hffff, 0, 0);
    // R1 back-pressure: held offer stays stable
    @(posedge clk); #1;
    out_ready = 1'b0; in_valid = 1'b1; op_code = 4'd0;
    op_a = 32'h7fffffff; op_b = 32'h2; use_imm = 0; is_unsigned = 0;
    @(negedge clk);
    check("R1", "in_ready stalled", {32'h0, in_ready}, 33'h0);
    check("R1", "stalled result", {ovf_trap, result}, {1'b1, 32'h80000001});
    @(negedge clk);
    check("R1", "held result", {ovf_trap, result}, {1'b1, 32'h80000001});
    @(posedge clk); #1; out_ready = 1'b1;
    @(negedge clk);
    check("R1", "in_ready released", {32'h0, in_ready}, 33'h1);
    @(posedge clk); #1; in_valid = 1'b0;
    @(negedge clk);
    check("R1", "idle out_valid", {32'h0, out_valid}, 33'h0);
    // random sweep over every code
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 4 == 0) ra = {ra[31], 31'h7ffffff0 | ra[3:0]};
      apply(i % 16, ra, rb, 16'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule